// File: doc/BRIEF.md
# Serial Clock Rate Divider for SPI Master

This block turns the internal clock into the timing reference for the serial clock of an SPI master. It has three division stages in series. The first is a prescaler with a factor from 1 to 8. The second is a rate-select stage with a factor of 2, 4, 16 or 32. The third is a divide-by-2 stage that can be bypassed. The overall division N is the product of the three factors. The block emits a one-cycle strobe `sck_toggle` every N/2 internal cycles, and the serial clock flips on each strobe. The serial clock therefore has period N and a duty cycle of exactly 50%.

The prescaler factor and the divide-by-2 control live in an 8-bit configuration register owned by this block. The rate-select code comes from the control register elsewhere and arrives on `rate_sel`. The counters run only while the peripheral is in master mode, the run enable is high and no configuration write is taking place. When any of these conditions is not met, every counter returns to zero, so the first strobe after a restart always falls at a known cycle.

The divide-by-2 stage is a two-state machine:
- It starts in `HALF_ARM` and stays there on reset, on a counter clear, and while it is bypassed.
- From `HALF_ARM`, a tick from the rate-select stage moves it to `HALF_FIRE` and produces no output.
- From `HALF_FIRE`, the next tick produces the output tick and returns it to `HALF_ARM`.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `sck_toggle` is 0.
- R2: Bits 7:5 and bit 3 of `cfg_rdata` always read 0, whatever value was written. Bits 4 and 2:0 read back the last written value.
- R3: Register bits 2:0 hold a value p. The prescaler stage divides by p+1.
- R4: `rate_sel` codes 00, 01, 10 and 11 select rate factors 2, 4, 16 and 32.
- R5: Register bit 4 = 0 inserts the divide-by-2 stage. Bit 4 = 1 bypasses it (factor 1).
- R6: While counting, `sck_toggle` is high after active edge i (counted from 1 since the last restart) exactly when i is a multiple of T = (p+1)·(rate factor/2)·(bit4 ? 1 : 2).
- R7: With `master_en` low (slave mode), `sck_toggle` stays 0 whatever the configuration.
- R8: A low `run_en`, a low `master_en` or a configuration write clears all counters. Counting then starts again from active edge 1.
- R9: For T > 1, `sck_toggle` is high for a single cycle at a time. For the minimum setting (p=0, code 00, bit 4 = 1) it is high on every active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | 8 | Write data for the configuration register |
| rate_sel | input | 2 | Rate-select code from the control register |
| master_en | input | 1 | 1 = master mode |
| run_en | input | 1 | Enables counting |
| sck_toggle | output | 1 | One-cycle strobe on which the serial clock flips |
| cfg_rdata | output | 8 | Readback of the configuration register |

## Verification
The bench sweeps all 64 combinations of prescaler value, rate-select code and divide-by-2 control, and checks the strobe on every cycle against T computed in the bench. This sweep catches three faults:
- An off-by-one prescaler shifts every strobe.
- A swapped rate-select entry shows up as the wrong interval for that code.
- An inverted sense on bit 4 doubles or halves the interval.

The minimum setting is covered as a separate case. A design that gates the strobe or leaves a counter stale there would miss strobes that should come on consecutive cycles. The bench also interrupts a count part-way through, once by dropping the run enable and once by leaving master mode. A design that does not clear its counters on a restart places the first strobe early. Writes with the reserved bits set expose any leak of those bits into the readback.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    localparam int CFG_W         = 8;
    localparam int PRE_LSB       = 0;
    localparam int PRE_W         = 3;
    localparam int HALF_OFF_BIT  = 4;
    localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 8'h17;

    localparam int RATE_SEL_W    = 2;
    localparam int RATE_CNT_W    = 4;

    typedef enum logic {
        HALF_ARM  = 1'b0,
        HALF_FIRE = 1'b1
    } half_state_e;

    // Terminal count of the rate stage: factor/2 - 1 for factors 2,4,16,32
    function automatic logic [RATE_CNT_W-1:0] rate_limit(input logic [RATE_SEL_W-1:0] code);
        logic [RATE_CNT_W-1:0] lim;
        unique case (code)
            2'b00:   lim = RATE_CNT_W'(0);
            2'b01:   lim = RATE_CNT_W'(1);
            2'b10:   lim = RATE_CNT_W'(7);
            default: lim = RATE_CNT_W'(15);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg
    import spi_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rdata,
    output logic [PRE_W-1:0] pre_limit,
    output logic             half_bypass
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data & CFG_KEEP_MASK;
        end
    end

    always_comb begin
        rdata       = cfg_q;
        pre_limit   = cfg_q[PRE_LSB +: PRE_W];
        half_bypass = cfg_q[HALF_OFF_BIT];
    end

endmodule

// File: rtl/spi_baud_stage.sv
module spi_baud_stage #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    // Compare with >= so that a limit lowered on the fly cannot strand the count
    always_comb begin
        tick = step && (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_baud_half.sv
module spi_baud_half
    import spi_baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bypass,
    input  logic step,
    output logic tick
);

    half_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HALF_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clear || bypass) begin
            state_d = HALF_ARM;
        end else begin
            unique case (state_q)
                HALF_ARM:  if (step) state_d = HALF_FIRE;
                HALF_FIRE: if (step) state_d = HALF_ARM;
                default:   state_d = HALF_ARM;
            endcase
        end
    end

    always_comb begin
        tick = 1'b0;
        if (bypass) begin
            tick = step;
        end else begin
            unique case (state_q)
                HALF_ARM:  tick = 1'b0;
                HALF_FIRE: tick = step;
                default:   tick = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CFG_W-1:0]      cfg_wr_data,
    input  logic [RATE_SEL_W-1:0] rate_sel,
    input  logic                  master_en,
    input  logic                  run_en,
    output logic                  sck_toggle,
    output logic [CFG_W-1:0]      cfg_rdata
);

    logic [PRE_W-1:0]      pre_limit;
    logic                  half_bypass;
    logic [RATE_CNT_W-1:0] rate_lim;
    logic                  active;
    logic                  clear;
    logic                  pre_tick;
    logic                  rate_tick;
    logic                  half_tick;
    logic                  toggle_q;

    always_comb begin
        active   = master_en && run_en && !cfg_wr_en;
        clear    = !active;
        rate_lim = rate_limit(rate_sel);
    end

    spi_baud_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_data     (cfg_wr_data),
        .rdata       (cfg_rdata),
        .pre_limit   (pre_limit),
        .half_bypass (half_bypass)
    );

    spi_baud_stage #(.CNT_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (active),
        .limit (pre_limit),
        .tick  (pre_tick)
    );

    spi_baud_stage #(.CNT_W(RATE_CNT_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (pre_tick),
        .limit (rate_lim),
        .tick  (rate_tick)
    );

    spi_baud_half u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .bypass (half_bypass),
        .step   (rate_tick),
        .tick   (half_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else begin
            toggle_q <= half_tick;
        end
    end

    assign sck_toggle = toggle_q;

endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_en,
    input logic [1:0] rate_sel,
    input logic       master_en,
    input logic       run_en,
    input logic       sck_toggle,
    input logic [7:0] cfg_rdata
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:5] == 3'b000) && !cfg_rdata[3]);

    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !sck_toggle);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || cfg_wr_en) |=> !sck_toggle);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_toggle && (cfg_rdata[2:0] != 3'd0)) |=> !sck_toggle);

    // R9
    min_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && run_en && !cfg_wr_en && cfg_rdata[2:0] == 3'd0
         && cfg_rdata[4] && rate_sel == 2'b00) |=> sck_toggle);

endmodule

bind spi_baud_gen spi_baud_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .rate_sel   (rate_sel),
    .master_en  (master_en),
    .run_en     (run_en),
    .sck_toggle (sck_toggle),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/spi_baud_gen_test.sv
`timescale 1ns/1ps
module spi_baud_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [1:0] rate_sel = 2'b00;
    logic       master_en = 1'b0;
    logic       run_en = 1'b0;
    logic       sck_toggle;
    logic [7:0] cfg_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_baud_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .rate_sel    (rate_sel),
        .master_en   (master_en),
        .run_en      (run_en),
        .sck_toggle  (sck_toggle),
        .cfg_rdata   (cfg_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int interval(input int pre, input int rs, input int off);
        int rf;
        case (rs)
            0: rf = 2;
            1: rf = 4;
            2: rf = 16;
            default: rf = 32;
        endcase
        return (pre + 1) * (rf / 2) * (off ? 1 : 2);
    endfunction

    // One write cycle; counters are cleared by it
    task automatic write_cfg(input logic [7:0] d);
        cfg_wr_data = d;
        cfg_wr_en   = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // Run n active edges from a fresh count start at i0+1
    task automatic run_check(input string req, input int t, input int i0, input int n);
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); @(negedge clk);
            chk(req, int'(sck_toggle), ((i0 + k) % t == 0) ? 1 : 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1 readback", int'(cfg_rdata), 0);
        chk("R1 strobe", int'(sck_toggle), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 readback after release", int'(cfg_rdata), 0);

        // R2: reserved bits masked
        write_cfg(8'hFF);
        chk("R2 all ones", int'(cfg_rdata), 8'h17);
        write_cfg(8'hE8);
        chk("R2 reserved only", int'(cfg_rdata), 8'h00);
        write_cfg(8'h15);
        chk("R2 kept bits", int'(cfg_rdata), 8'h15);

        // R7: slave mode, no strobe even at minimum setting
        master_en = 1'b0;
        run_en    = 1'b1;
        write_cfg(8'h10);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R7 slave quiet", int'(sck_toggle), 0);
        end

        // R3 R4 R5 R6 sweep in master mode
        master_en = 1'b1;
        for (int off = 0; off < 2; off++) begin
            for (int rs = 0; rs < 4; rs++) begin
                for (int pre = 0; pre < 8; pre++) begin
                    int t;
                    t = interval(pre, rs, off);
                    rate_sel = 2'(rs);
                    write_cfg({3'b111, 1'(off), 1'b1, 3'(pre)});
                    chk("R2 sweep readback", int'(cfg_rdata), (off << 4) | pre);
                    chk("R8 quiet after write", int'(sck_toggle), 0);
                    run_check(off ? "R3 R4 R6 bypass" : "R3 R4 R5 R6 halved", t, 0, 2 * t + 2);
                end
            end
        end

        // R9: minimum setting strobes every cycle
        rate_sel = 2'b00;
        write_cfg(8'h10);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 every cycle", int'(sck_toggle), 1);
        end

        // R8: run_en restart, T = 3
        write_cfg(8'h12);
        run_check("R8 before pause", 3, 0, 2);
        run_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R8 paused quiet", int'(sck_toggle), 0);
        end
        run_en = 1'b1;
        run_check("R8 restart run_en", 3, 0, 7);

        // R8 R7: leaving master mode mid-count restarts it
        run_check("R8 partial", 3, 0, 1);
        master_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 slave mid-run", int'(sck_toggle), 0);
        master_en = 1'b1;
        run_check("R8 restart master_en", 3, 0, 7);

        // R5: same prescaler/rate, divide-by-2 on vs off
        rate_sel = 2'b01;
        write_cfg(8'h01);
        run_check("R5 halved on", 8, 0, 17);
        write_cfg(8'h11);
        run_check("R5 bypassed", 4, 0, 9);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule